// File: doc/BRIEF.md
# Spare Module Reallocator

This block keeps the assignment map of a pool of identical processing modules. Each slot has a fixed module type and sits in a fixed rack. When a health monitor reports that a slot has failed, the block moves the function that slot was carrying onto a free, healthy spare of the same type. When no spare of that type is left, it uses a per-function priority table. If the lost function outranks the weakest function still running on that type, it takes over that module. If it does not, the lost function is dropped.

Losing a whole rack takes a separate path. The block marks every slot of the lost rack as failed and clears the assignment map. It then loads a fixed emergency set of functions onto the first slots of a surviving rack. Every reassignment leaves the block as a one-cycle reprogram command carrying a slot and a function number, meant for the maintenance path rather than the main data bus. A busy flag marks the cycles in which a new report is not accepted. A mode output tells whether the system still runs at full capability, runs degraded, or runs in the emergency configuration.

Top module: `spare_realloc`

## Requirements
- R1: After reset, busy_o and cmd_valid_o are low and mode_o is 0 (full capability). Slot s carries function s for s below NUM_ACTIVE, and the remaining slots are free spares. A slot's type is its index modulo NUM_TYPES, and its rack is its index divided by NUM_SLOTS/NUM_RACKS. The mode codes are 0 for full, 1 for degraded and 2 for emergency.
- R2: A fault report is accepted on a clock edge where busy_o is low. busy_o is then high for one cycle. The decision is taken at the next edge, which lowers busy_o, and any resulting command is shown for exactly one cycle.
- R3: If the failed slot was healthy and assigned, its function moves to the lowest-index free healthy slot of the same type. That slot and function are issued as a command, and the mode is unchanged.
- R4: A lost function is only ever placed on a slot of the same type as the slot that failed.
- R5: With no spare of that type left, the victim is the healthy assigned slot of that type whose function has the lowest priority. On equal priority, the function with the higher index is the victim. The lost function takes the victim's slot if its priority is higher, or if the priorities are equal and its index is lower. The mode becomes degraded.
- R6: If the lost function does not outrank that victim, or the type has no other healthy assigned slot, the lost function is dropped. No command is issued and the mode becomes degraded.
- R7: A report for a slot that is already failed, or that carries no function, issues no command and leaves the mode unchanged. The slot is still marked failed and is never chosen later.
- R8: A fault report presented while busy_o is high is not accepted and has no later effect.
- R9: A rack-loss report marks every slot of that rack as failed and clears all assignments. It then issues commands on consecutive cycles, placing emergency functions EMERG_BASE onward on the first EMERG_COUNT slots of the lowest-index other rack, in slot order. The mode becomes emergency.
- R10: A rack-loss report outranks a fault report presented on the same edge. A degraded mode never returns to full, and emergency mode stays until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fault_valid_i | input | 1 | A module fault report is present |
| fault_slot_i | input | SLOT_W | Slot named by the fault report |
| rack_loss_i | input | 1 | A whole-rack loss report is present |
| rack_id_i | input | RACK_W | Rack named by the rack-loss report |
| prio_table_i | input | NUM_FUNCS*PRIO_W | Priority of each function, function f in bits f*PRIO_W upward |
| busy_o | output | 1 | A decision or emergency load is in progress |
| cmd_valid_o | output | 1 | Reprogram command present this cycle |
| cmd_slot_o | output | SLOT_W | Slot to reprogram |
| cmd_func_o | output | FUNC_W | Function to load into that slot |
| mode_o | output | 2 | Operating mode: 0 full, 1 degraded, 2 emergency |

## Verification
The bench uses the default parameters: 16 slots of 4 types in 2 racks, 16 functions with 12 active at reset, and a four-function emergency set. This leaves exactly one spare per type, so the second failure on a type already reaches the eviction path and the third reaches the drop path. The bench's priority table holds equal-priority pairs on two types, which brings both directions of the index tie-break within reach. With two racks, loss of either rack moves the emergency set to the other rack, so both emergency placements can be observed.

// File: rtl/realloc_pkg.sv
package realloc_pkg;

    typedef enum logic [1:0] {
        MODE_FULL      = 2'd0,
        MODE_DEGRADED  = 2'd1,
        MODE_EMERGENCY = 2'd2
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_EMERG  = 2'd2
    } phase_e;

endpackage

// File: rtl/spare_finder.sv
module spare_finder #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TYPES = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TYPE_W = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
    input  logic [TYPE_W-1:0]    type_sel_i,
    input  logic [NUM_SLOTS-1:0] used_i,
    input  logic [NUM_SLOTS-1:0] excl_i,
    output logic                 found_o,
    output logic [SLOT_W-1:0]    slot_o
);

    // Scan downward so the lowest matching index is the one that remains.
    always_comb begin
        found_o = 1'b0;
        slot_o  = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if ((s % NUM_TYPES) == int'(type_sel_i) && !used_i[s] && !excl_i[s]) begin
                found_o = 1'b1;
                slot_o  = SLOT_W'(s);
            end
        end
    end

endmodule

// File: rtl/victim_picker.sv
module victim_picker #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TYPES = 4,
    parameter int NUM_FUNCS = 16,
    parameter int PRIO_W    = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TYPE_W = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
    localparam int FUNC_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
    input  logic [TYPE_W-1:0]                 type_sel_i,
    input  logic [NUM_SLOTS-1:0]              used_i,
    input  logic [NUM_SLOTS-1:0]              excl_i,
    input  logic [NUM_SLOTS-1:0][FUNC_W-1:0]  func_i,
    input  logic [NUM_FUNCS*PRIO_W-1:0]       prio_table_i,
    output logic                              found_o,
    output logic [SLOT_W-1:0]                 slot_o,
    output logic [FUNC_W-1:0]                 func_o,
    output logic [PRIO_W-1:0]                 prio_o
);

    // Weakest function: lowest priority, then the highest function index.
    always_comb begin
        logic [PRIO_W-1:0] p;
        found_o = 1'b0;
        slot_o  = '0;
        func_o  = '0;
        prio_o  = '0;
        p       = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            p = prio_table_i[int'(func_i[s])*PRIO_W +: PRIO_W];
            if ((s % NUM_TYPES) == int'(type_sel_i) && used_i[s] && !excl_i[s]) begin
                if (!found_o || p < prio_o || (p == prio_o && func_i[s] > func_o)) begin
                    found_o = 1'b1;
                    slot_o  = SLOT_W'(s);
                    func_o  = func_i[s];
                    prio_o  = p;
                end
            end
        end
    end

endmodule

// File: rtl/spare_realloc.sv
module spare_realloc
    import realloc_pkg::*;
#(
    parameter int NUM_SLOTS   = 16,
    parameter int NUM_TYPES   = 4,
    parameter int NUM_RACKS   = 2,
    parameter int NUM_FUNCS   = 16,
    parameter int PRIO_W      = 4,
    parameter int NUM_ACTIVE  = 12,
    parameter int EMERG_BASE  = 0,
    parameter int EMERG_COUNT = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TYPE_W = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
    localparam int FUNC_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
    localparam int RACK_W = (NUM_RACKS > 1) ? $clog2(NUM_RACKS) : 1,
    localparam int EMG_W  = (EMERG_COUNT > 1) ? $clog2(EMERG_COUNT) : 1,
    localparam int SLOTS_PER_RACK = NUM_SLOTS / NUM_RACKS
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        fault_valid_i,
    input  logic [SLOT_W-1:0]           fault_slot_i,
    input  logic                        rack_loss_i,
    input  logic [RACK_W-1:0]           rack_id_i,
    input  logic [NUM_FUNCS*PRIO_W-1:0] prio_table_i,
    output logic                        busy_o,
    output logic                        cmd_valid_o,
    output logic [SLOT_W-1:0]           cmd_slot_o,
    output logic [FUNC_W-1:0]           cmd_func_o,
    output logic [1:0]                  mode_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0]             failed;
        logic [NUM_SLOTS-1:0]             used;
        logic [NUM_SLOTS-1:0][FUNC_W-1:0] func;
        phase_e                           phase;
        logic [SLOT_W-1:0]                req_slot;
        logic [RACK_W-1:0]                emg_rack;
        logic [EMG_W-1:0]                 emg_idx;
        op_mode_e                         mode;
        logic                             cmd_valid;
        logic [SLOT_W-1:0]                cmd_slot;
        logic [FUNC_W-1:0]                cmd_func;
    } state_t;

    function automatic state_t boot_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i < NUM_ACTIVE) begin
                s.used[i] = 1'b1;
                s.func[i] = FUNC_W'(i);
            end
        end
        s.phase = ST_IDLE;
        s.mode  = MODE_FULL;
        return s;
    endfunction

    state_t r_q, r_d;

    // Lookup inputs for the two pickers, derived from the latched request.
    logic [NUM_SLOTS-1:0] excl;
    logic [TYPE_W-1:0]    req_type;
    logic [FUNC_W-1:0]    lost_func;
    logic [PRIO_W-1:0]    lost_prio;
    logic [RACK_W-1:0]    work_rack;

    always_comb begin
        excl                = r_q.failed;
        excl[r_q.req_slot]  = 1'b1;
        req_type            = TYPE_W'(int'(r_q.req_slot) % NUM_TYPES);
        lost_func           = r_q.func[r_q.req_slot];
        lost_prio           = prio_table_i[int'(lost_func)*PRIO_W +: PRIO_W];
        work_rack           = '0;
        for (int rk = NUM_RACKS - 1; rk >= 0; rk--) begin
            if (rk != int'(rack_id_i)) begin
                work_rack = RACK_W'(rk);
            end
        end
    end

    logic              spare_found;
    logic [SLOT_W-1:0] spare_slot;
    logic              vic_found;
    logic [SLOT_W-1:0] vic_slot;
    logic [FUNC_W-1:0] vic_func;
    logic [PRIO_W-1:0] vic_prio;

    spare_finder #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_TYPES (NUM_TYPES)
    ) u_spare (
        .type_sel_i (req_type),
        .used_i     (r_q.used),
        .excl_i     (excl),
        .found_o    (spare_found),
        .slot_o     (spare_slot)
    );

    victim_picker #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_TYPES (NUM_TYPES),
        .NUM_FUNCS (NUM_FUNCS),
        .PRIO_W    (PRIO_W)
    ) u_victim (
        .type_sel_i   (req_type),
        .used_i       (r_q.used),
        .excl_i       (excl),
        .func_i       (r_q.func),
        .prio_table_i (prio_table_i),
        .found_o      (vic_found),
        .slot_o       (vic_slot),
        .func_o       (vic_func),
        .prio_o       (vic_prio)
    );

    logic              lost_wins;
    logic [SLOT_W-1:0] emg_slot;
    logic [FUNC_W-1:0] emg_func;

    always_comb begin
        lost_wins = vic_found &&
                    (lost_prio > vic_prio || (lost_prio == vic_prio && lost_func < vic_func));
        emg_slot  = SLOT_W'(int'(r_q.emg_rack) * SLOTS_PER_RACK + int'(r_q.emg_idx));
        emg_func  = FUNC_W'(EMERG_BASE + int'(r_q.emg_idx));
    end

    always_comb begin
        r_d           = r_q;
        r_d.cmd_valid = 1'b0;
        unique case (r_q.phase)
            ST_IDLE: begin
                if (rack_loss_i) begin
                    r_d.phase    = ST_EMERG;
                    r_d.emg_rack = work_rack;
                    r_d.emg_idx  = '0;
                    r_d.mode     = MODE_EMERGENCY;
                    r_d.used     = '0;
                    for (int s = 0; s < NUM_SLOTS; s++) begin
                        if ((s / SLOTS_PER_RACK) == int'(rack_id_i)) begin
                            r_d.failed[s] = 1'b1;
                        end
                    end
                end else if (fault_valid_i) begin
                    r_d.phase    = ST_DECIDE;
                    r_d.req_slot = fault_slot_i;
                end
            end
            ST_DECIDE: begin
                r_d.phase                = ST_IDLE;
                r_d.failed[r_q.req_slot] = 1'b1;
                if (r_q.used[r_q.req_slot] && !r_q.failed[r_q.req_slot]) begin
                    r_d.used[r_q.req_slot] = 1'b0;
                    if (spare_found) begin
                        r_d.used[spare_slot] = 1'b1;
                        r_d.func[spare_slot] = lost_func;
                        r_d.cmd_valid        = 1'b1;
                        r_d.cmd_slot         = spare_slot;
                        r_d.cmd_func         = lost_func;
                    end else begin
                        if (r_q.mode == MODE_FULL) begin
                            r_d.mode = MODE_DEGRADED;
                        end
                        if (lost_wins) begin
                            r_d.func[vic_slot] = lost_func;
                            r_d.cmd_valid      = 1'b1;
                            r_d.cmd_slot       = vic_slot;
                            r_d.cmd_func       = lost_func;
                        end
                    end
                end
            end
            ST_EMERG: begin
                r_d.used[emg_slot] = 1'b1;
                r_d.func[emg_slot] = emg_func;
                r_d.cmd_valid      = 1'b1;
                r_d.cmd_slot       = emg_slot;
                r_d.cmd_func       = emg_func;
                if (int'(r_q.emg_idx) == EMERG_COUNT - 1) begin
                    r_d.phase = ST_IDLE;
                end else begin
                    r_d.emg_idx = r_q.emg_idx + 1'b1;
                end
            end
            default: r_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= boot_state();
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.phase != ST_IDLE);
    assign cmd_valid_o = r_q.cmd_valid;
    assign cmd_slot_o  = r_q.cmd_slot;
    assign cmd_func_o  = r_q.cmd_func;
    assign mode_o      = r_q.mode;

    // Internal views for the bound checker.
    logic [NUM_SLOTS-1:0] failed_vec;
    logic [SLOT_W-1:0]    req_slot_vec;
    logic                 deciding;
    logic                 emerging;

    assign failed_vec   = r_q.failed;
    assign req_slot_vec = r_q.req_slot;
    assign deciding     = (r_q.phase == ST_DECIDE);
    assign emerging     = (r_q.phase == ST_EMERG);

endmodule

// File: rtl/realloc_checker.sv
module realloc_checker #(
    parameter int NUM_SLOTS   = 16,
    parameter int NUM_TYPES   = 4,
    parameter int EMERG_BASE  = 0,
    parameter int EMERG_COUNT = 4,
    parameter int SLOT_W      = 4,
    parameter int FUNC_W      = 4
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 fault_valid_i,
    input logic                 rack_loss_i,
    input logic                 busy_o,
    input logic                 cmd_valid_o,
    input logic [SLOT_W-1:0]    cmd_slot_o,
    input logic [FUNC_W-1:0]    cmd_func_o,
    input logic [1:0]           mode_o,
    input logic [NUM_SLOTS-1:0] failed_vec,
    input logic [SLOT_W-1:0]    req_slot_vec,
    input logic                 deciding,
    input logic                 emerging
);

    assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_valid_i && !busy_o && !rack_loss_i) |=> busy_o);

    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && !busy_o) |=> !cmd_valid_o);

    assert_same_type_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        deciding |=> (!cmd_valid_o ||
            ((int'(cmd_slot_o) % NUM_TYPES) == (int'($past(req_slot_vec)) % NUM_TYPES))));

    assert_target_healthy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        deciding |=> (!cmd_valid_o || !failed_vec[cmd_slot_o]));

    assert_emerg_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        emerging |=> (cmd_valid_o && int'(cmd_func_o) >= EMERG_BASE &&
                      int'(cmd_func_o) < EMERG_BASE + EMERG_COUNT));

    assert_no_return_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o != 2'd0) |=> (mode_o != 2'd0));

    assert_emerg_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd2) |=> (mode_o == 2'd2));

endmodule

bind spare_realloc realloc_checker #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_TYPES   (NUM_TYPES),
    .EMERG_BASE  (EMERG_BASE),
    .EMERG_COUNT (EMERG_COUNT),
    .SLOT_W      (SLOT_W),
    .FUNC_W      (FUNC_W)
) u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_valid_i (fault_valid_i),
    .rack_loss_i   (rack_loss_i),
    .busy_o        (busy_o),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_slot_o    (cmd_slot_o),
    .cmd_func_o    (cmd_func_o),
    .mode_o        (mode_o),
    .failed_vec    (failed_vec),
    .req_slot_vec  (req_slot_vec),
    .deciding      (deciding),
    .emerging      (emerging)
);

// File: tb/spare_realloc_bench.sv
module spare_realloc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [3:0]  fault_slot = '0;
    logic        rack_loss = 1'b0;
    logic [0:0]  rack_id = '0;
    logic [63:0] prio_table;
    logic        busy;
    logic        cmd_valid;
    logic [3:0]  cmd_slot;
    logic [3:0]  cmd_func;
    logic [1:0]  mode;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spare_realloc u_spare_realloc (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .fault_valid_i (fault_valid),
        .fault_slot_i  (fault_slot),
        .rack_loss_i   (rack_loss),
        .rack_id_i     (rack_id),
        .prio_table_i  (prio_table),
        .busy_o        (busy),
        .cmd_valid_o   (cmd_valid),
        .cmd_slot_o    (cmd_slot),
        .cmd_func_o    (cmd_func),
        .mode_o        (mode)
    );

    // Priorities: 0-3 -> 15, 4 -> 2, 5 -> 9, 6 -> 7, 7 -> 8, 8 -> 5, 9 -> 4, 10 -> 7, 11 -> 8, 12-15 -> 1
    localparam logic [3:0] PRIO [16] = '{4'd15, 4'd15, 4'd15, 4'd15, 4'd2, 4'd9, 4'd7, 4'd8,
                                         4'd5, 4'd4, 4'd7, 4'd8, 4'd1, 4'd1, 4'd1, 4'd1};

    // {fault slot, expect command, expected slot, expected function, expected mode}
    localparam logic [14:0] VEC [12] = '{
        {4'd4,  1'b1, 4'd12, 4'd4, 2'd0},
        {4'd4,  1'b0, 4'd0,  4'd0, 2'd0},
        {4'd0,  1'b1, 4'd12, 4'd0, 2'd1},
        {4'd12, 1'b1, 4'd8,  4'd0, 2'd1},
        {4'd8,  1'b0, 4'd0,  4'd0, 2'd1},
        {4'd5,  1'b1, 4'd13, 4'd5, 2'd1},
        {4'd9,  1'b0, 4'd0,  4'd0, 2'd1},
        {4'd2,  1'b1, 4'd14, 4'd2, 2'd1},
        {4'd6,  1'b1, 4'd10, 4'd6, 2'd1},
        {4'd3,  1'b1, 4'd15, 4'd3, 2'd1},
        {4'd11, 1'b0, 4'd0,  4'd0, 2'd1},
        {4'd7,  1'b0, 4'd0,  4'd0, 2'd1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 5, 7, 9: return "R3";
            1:          return "R7";
            2, 3, 8:    return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        fault_valid = 1'b0;
        rack_loss   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report(input logic [3:0] slot, input bit ev, input logic [3:0] es,
                          input logic [3:0] ef, input logic [1:0] em, input string req);
        @(negedge clk);
        fault_valid = 1'b1;
        fault_slot  = slot;
        @(negedge clk);
        fault_valid = 1'b0;
        check("R2", "busy after accept", int'(busy), 1);
        @(negedge clk);
        check("R2", "busy after decision", int'(busy), 0);
        check(req, "cmd_valid", int'(cmd_valid), int'(ev));
        if (ev) begin
            check(req, "cmd_slot", int'(cmd_slot), int'(es));
            check(req, "cmd_func", int'(cmd_func), int'(ef));
        end
        check(req, "mode", int'(mode), int'(em));
        @(negedge clk);
        check("R2", "pulse ends", int'(cmd_valid), 0);
    endtask

    task automatic rack_drop(input logic [0:0] rk, input int first_slot, input bit poke);
        @(negedge clk);
        rack_loss   = 1'b1;
        rack_id     = rk;
        fault_valid = 1'b1;
        fault_slot  = 4'd9;
        @(negedge clk);
        rack_loss   = 1'b0;
        fault_valid = 1'b0;
        check("R9", "busy during load", int'(busy), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0 && poke) begin
                fault_valid = 1'b1;
                fault_slot  = 4'd8;
            end
            if (k == 1) fault_valid = 1'b0;
            check("R9", "emergency cmd_valid", int'(cmd_valid), 1);
            check("R9", "emergency cmd_slot", int'(cmd_slot), first_slot + k);
            check("R9", "emergency cmd_func", int'(cmd_func), k);
            check("R9", "emergency mode", int'(mode), 2);
        end
        check("R9", "busy after load", int'(busy), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", "no extra command", int'(cmd_valid), 0);
        end
    endtask

    initial begin
        for (int f = 0; f < 16; f++) prio_table[f*4 +: 4] = PRIO[f];
        do_reset();
        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "cmd_valid", int'(cmd_valid), 0);
        check("R1", "mode", int'(mode), 0);

        for (int i = 0; i < 12; i++) begin
            report(VEC[i][14:11], VEC[i][10], VEC[i][9:6], VEC[i][5:2], VEC[i][1:0], vec_tag(i));
        end

        // R7 + R4: unassigned spare reported, then its type runs out and evicts (tie-break)
        do_reset();
        report(4'd15, 1'b0, 4'd0, 4'd0, 2'd0, "R7");
        report(4'd3, 1'b1, 4'd11, 4'd3, 2'd1, "R4");

        // R9 + R10 + R8: rack 0 lost with a simultaneous fault; a fault during load is ignored
        do_reset();
        rack_drop(1'b0, 8, 1'b1);
        report(4'd8, 1'b1, 4'd12, 4'd0, 2'd2, "R10");

        // R9: rack 1 lost, emergency set lands on rack 0
        do_reset();
        rack_drop(1'b1, 0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule